// File: doc/BRIEF.md
# Auto-Incrementing Serial Register Bank

This block is a byte-wide register bank that sits behind a two-wire serial slave. The bit-level front end has already turned bus activity into single-cycle strobes: a start (or repeated start), a stop, a received byte and a request for a byte to send. The first byte received after a start loads an address pointer that can never be read back. Each later byte is written to, or read from, the register the pointer names, and the pointer then steps forward by one. It does this until a stop ends the transaction. A read transaction that sends no pointer byte starts at the address left over from the previous transaction.

The register map is sparse. Status and two 16-bit conversion results (high byte at the lower address) are read-only. Offset, gain, per-channel setup, configuration, two capacitive-DAC and a second configuration register are read/write. Unused bits and unmapped addresses always read 0. A converter-side port loads new results. A result that arrives while a bus read is in progress is dropped, so a host never sees the two halves of a value from different conversions. The transaction sequencer has three states. **IDLE** moves to **ADDR** on a start. In **ADDR**, a received byte loads the pointer and moves to **DATA**. A read request in **ADDR** reads from the current pointer and also moves to **DATA**. **DATA** stays in **DATA** on each byte. A start from any state goes to **ADDR**, and a stop from any state goes to **IDLE**.

Top module: `capbank_if`

## Requirements
- R1: After reset: status reads 0x03, all four data bytes read 0x00, offset high bytes (0x05, 0x07) read 0x80, gain bytes (0x09/0x0A and 0x0C/0x0D) read the high and low bytes of the GAIN1_DEFAULT and GAIN2_DEFAULT parameters, and every other address reads 0x00.
- R2: A start in any state enters ADDR and wins over a stop in the same cycle. A stop alone enters IDLE. Byte strobes in IDLE, or in the same cycle as a start or stop, have no effect on the pointer or on the registers.
- R3: In ADDR, a received byte loads its low ADDR_W bits into the pointer, writes no register and moves to DATA.
- R4: In ADDR, a read request returns the byte at the pointer retained from earlier transactions and moves to DATA.
- R5: Each byte written or read in DATA, and a read in ADDR, advances the pointer by one, wrapping from 0x1F to 0x00.
- R6: rd_data takes the addressed byte one cycle after a read request and otherwise holds its value. If a write and a read strobe arrive together, the write wins.
- R7: Writes to 0x00–0x04, 0x13–0x19 and 0x1B–0x1F are ignored. Unmapped addresses read 0x00.
- R8: Written bytes are masked: setup bytes (0x0B, 0x0E) keep bits 7..5, configuration (0x0F) keeps bits 4..0, 0x10 keeps none, DAC bytes (0x11, 0x12) keep bit 7 and bits 4..0, configuration2 (0x1A) keeps bits 5..4, and all other read/write bytes keep all bits. Status bits 7..3 read 0.
- R9: ch1_en = 0x0F bit 4, ch2_en = 0x0F bit 3, conv_mode = 0x0F bits 2..0 and osr_sel = 0x1A bits 5..4. They change only in the cycle after a write.
- R10: A res_load pulse stores {res_value, 4'b0} into the data register of res_chan (0: 0x01/0x02, 1: 0x03/0x04). It clears that channel's ready bit (status bit 0 for channel 0, bit 1 for channel 1) and sets status bit 2 to res_chan.
- R11: Reading a channel's low data byte (0x02 or 0x04) sets that channel's ready bit back to 1.
- R12: A res_load is dropped if it arrives in the cycle of a read or at any time after a read, up to and including the stop that ends the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Start or repeated-start strobe |
| bus_stop | input | 1 | Stop strobe |
| wr_valid | input | 1 | Received-byte strobe |
| wr_data | input | 8 | Received byte |
| rd_req | input | 1 | Request for the next byte to send |
| rd_data | output | 8 | Byte to send, valid the cycle after rd_req |
| res_load | input | 1 | New conversion result strobe |
| res_chan | input | 1 | Channel of the new result |
| res_value | input | RES_W | Conversion result |
| ch1_en | output | 1 | Channel 1 enable |
| ch2_en | output | 1 | Channel 2 enable |
| conv_mode | output | 3 | Conversion mode field |
| osr_sel | output | 2 | Oversampling field |

## Verification
The assertions check on every cycle that a start always lands in ADDR, that the pointer is frozen in IDLE and steps by exactly one per data byte, that rd_data and the configuration outputs move only after a read or write strobe, and that status bits 7..3 read zero. The register defaults, the write masks, the dropped writes to read-only and unmapped bytes, the wrap of the pointer, the status and ready-bit behaviour, the result dropped during a read, and start winning over stop can only be shown by the bench's directed transactions.

// File: rtl/capbank_pkg.sv
package capbank_pkg;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_ADDR = 2'd1,
        XS_DATA = 2'd2
    } xfer_state_t;

    localparam int A_STATUS = 0;
    localparam int A_D1H    = 1;
    localparam int A_D1L    = 2;
    localparam int A_D2H    = 3;
    localparam int A_D2L    = 4;
    localparam int A_OFS1H  = 5;
    localparam int A_OFS2H  = 7;
    localparam int A_G1H    = 9;
    localparam int A_G1L    = 10;
    localparam int A_G2H    = 12;
    localparam int A_G2L    = 13;
    localparam int A_CFG    = 15;
    localparam int A_CFG2   = 26;

    // Writable bits per address; zero for read-only and unmapped bytes.
    function automatic logic [7:0] wr_mask(input int a);
        case (a)
            5, 6, 7, 8, 9, 10, 12, 13: wr_mask = 8'hFF;
            11, 14:                    wr_mask = 8'hE0;
            15:                        wr_mask = 8'h1F;
            17, 18:                    wr_mask = 8'h9F;
            26:                        wr_mask = 8'h30;
            default:                   wr_mask = 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] rst_byte(input int a, input logic [15:0] g1,
                                            input logic [15:0] g2);
        case (a)
            A_OFS1H, A_OFS2H: rst_byte = 8'h80;
            A_G1H:            rst_byte = g1[15:8];
            A_G1L:            rst_byte = g1[7:0];
            A_G2H:            rst_byte = g2[15:8];
            A_G2L:            rst_byte = g2[7:0];
            default:          rst_byte = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/capbank_seq.sv
module capbank_seq
    import capbank_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              wr_valid,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] ptr_byte,
    output xfer_state_t       state,
    output logic [ADDR_W-1:0] ptr,
    output logic              wr_en,
    output logic              rd_en,
    output logic              rd_busy
);

    xfer_state_t nxt;
    logic        ptr_ld;
    logic        ptr_inc;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= XS_IDLE;
        else        state <= nxt;
    end

    // Pointer and read-in-progress flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            rd_busy <= 1'b0;
        end else begin
            if (ptr_ld)       ptr <= ptr_byte;
            else if (ptr_inc) ptr <= ptr + 1'b1;
            if (bus_stop)     rd_busy <= 1'b0;
            else if (rd_en)   rd_busy <= 1'b1;
        end
    end

    // Next state and strobes
    always_comb begin
        nxt     = state;
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        ptr_ld  = 1'b0;
        ptr_inc = 1'b0;
        if (bus_start) begin
            nxt = XS_ADDR;
        end else if (bus_stop) begin
            nxt = XS_IDLE;
        end else begin
            unique case (state)
                XS_IDLE: begin
                    nxt = XS_IDLE;
                end
                XS_ADDR: begin
                    if (wr_valid) begin
                        ptr_ld = 1'b1;
                        nxt    = XS_DATA;
                    end else if (rd_req) begin
                        rd_en   = 1'b1;
                        ptr_inc = 1'b1;
                        nxt     = XS_DATA;
                    end
                end
                XS_DATA: begin
                    if (wr_valid) begin
                        wr_en   = 1'b1;
                        ptr_inc = 1'b1;
                    end else if (rd_req) begin
                        rd_en   = 1'b1;
                        ptr_inc = 1'b1;
                    end
                end
                default: nxt = XS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/capbank_store.sv
module capbank_store
    import capbank_pkg::*;
#(
    parameter int          ADDR_W        = 5,
    parameter int          RES_W         = 12,
    parameter logic [15:0] GAIN1_DEFAULT = 16'h5A3C,
    parameter logic [15:0] GAIN2_DEFAULT = 16'hC3A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              res_take,
    input  logic              res_chan,
    input  logic [RES_W-1:0]  res_value,
    output logic [7:0]        rd_data,
    output logic [7:0]        cfg_byte,
    output logic [7:0]        cfg2_byte
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int PAD_W = 16 - RES_W;

    logic [7:0]  mem [DEPTH];
    logic [15:0] data1, data2;
    logic [1:0]  rdy_n;
    logic        last_ch;
    logic [7:0]  rd_sel;

    // Read/write bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= rst_byte(i, GAIN1_DEFAULT, GAIN2_DEFAULT);
        end else if (wr_en) begin
            mem[addr] <= wdata & wr_mask(int'(addr));
        end
    end

    // Results and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data1   <= '0;
            data2   <= '0;
            rdy_n   <= 2'b11;
            last_ch <= 1'b0;
        end else begin
            if (res_take) begin
                if (res_chan) data2 <= {res_value, {PAD_W{1'b0}}};
                else          data1 <= {res_value, {PAD_W{1'b0}}};
                rdy_n[res_chan] <= 1'b0;
                last_ch         <= res_chan;
            end
            if (rd_en && int'(addr) == A_D1L) rdy_n[0] <= 1'b1;
            if (rd_en && int'(addr) == A_D2L) rdy_n[1] <= 1'b1;
        end
    end

    always_comb begin
        case (int'(addr))
            A_STATUS: rd_sel = {5'b0, last_ch, rdy_n};
            A_D1H:    rd_sel = data1[15:8];
            A_D1L:    rd_sel = data1[7:0];
            A_D2H:    rd_sel = data2[15:8];
            A_D2L:    rd_sel = data2[7:0];
            default:  rd_sel = mem[addr];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= 8'h00;
        else if (rd_en) rd_data <= rd_sel;
    end

    assign cfg_byte  = mem[A_CFG];
    assign cfg2_byte = mem[A_CFG2];

endmodule

// File: rtl/capbank_if.sv
module capbank_if
    import capbank_pkg::*;
#(
    parameter int          ADDR_W        = 5,
    parameter int          RES_W         = 12,
    parameter logic [15:0] GAIN1_DEFAULT = 16'h5A3C,
    parameter logic [15:0] GAIN2_DEFAULT = 16'hC3A5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    input  logic             rd_req,
    output logic [7:0]       rd_data,
    input  logic             res_load,
    input  logic             res_chan,
    input  logic [RES_W-1:0] res_value,
    output logic             ch1_en,
    output logic             ch2_en,
    output logic [2:0]       conv_mode,
    output logic [1:0]       osr_sel
);

    xfer_state_t       st;
    logic [ADDR_W-1:0] ptr;
    logic              wr_en, rd_en, rd_busy;
    logic [7:0]        cfg_byte, cfg2_byte;
    logic              res_take;

    capbank_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_start(bus_start),
        .bus_stop (bus_stop),
        .wr_valid (wr_valid),
        .rd_req   (rd_req),
        .ptr_byte (wr_data[ADDR_W-1:0]),
        .state    (st),
        .ptr      (ptr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .rd_busy  (rd_busy)
    );

    // A result arriving during a bus read is lost.
    assign res_take = res_load && !rd_busy && !rd_en;

    capbank_store #(
        .ADDR_W       (ADDR_W),
        .RES_W        (RES_W),
        .GAIN1_DEFAULT(GAIN1_DEFAULT),
        .GAIN2_DEFAULT(GAIN2_DEFAULT)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (ptr),
        .wdata    (wr_data),
        .res_take (res_take),
        .res_chan (res_chan),
        .res_value(res_value),
        .rd_data  (rd_data),
        .cfg_byte (cfg_byte),
        .cfg2_byte(cfg2_byte)
    );

    assign ch1_en    = cfg_byte[4];
    assign ch2_en    = cfg_byte[3];
    assign conv_mode = cfg_byte[2:0];
    assign osr_sel   = cfg2_byte[5:4];

endmodule

// File: rtl/capbank_if_chk.sv
module capbank_if_chk
    import capbank_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_start,
    input logic              bus_stop,
    input logic              wr_valid,
    input logic              rd_req,
    input logic [7:0]        rd_data,
    input xfer_state_t       st,
    input logic [ADDR_W-1:0] ptr,
    input logic              ch1_en,
    input logic              ch2_en,
    input logic [2:0]        conv_mode,
    input logic [1:0]        osr_sel
);

    assert_start_enters_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> st == XS_ADDR);

    assert_idle_ptr_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == XS_IDLE && !bus_start) |=> $stable(ptr));

    assert_ptr_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == XS_DATA && !bus_start && !bus_stop && (wr_valid || rd_req))
        |=> ptr == ADDR_W'($past(ptr) + 1'b1));

    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));

    assert_status_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !wr_valid && !bus_start && !bus_stop && st != XS_IDLE && ptr == '0)
        |=> rd_data[7:3] == 5'b0);

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable({ch1_en, ch2_en, conv_mode, osr_sel}));

endmodule

bind capbank_if capbank_if_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .wr_valid (wr_valid),
    .rd_req   (rd_req),
    .rd_data  (rd_data),
    .st       (st),
    .ptr      (ptr),
    .ch1_en   (ch1_en),
    .ch2_en   (ch2_en),
    .conv_mode(conv_mode),
    .osr_sel  (osr_sel)
);

// File: tb/capbank_if_test.sv
`timescale 1ns/1ps
module capbank_if_test;

    localparam logic [15:0] G1 = 16'h5A3C;
    localparam logic [15:0] G2 = 16'hC3A5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0, bus_stop = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       res_load = 1'b0, res_chan = 1'b0;
    logic [11:0] res_value = 12'h000;
    logic       ch1_en, ch2_en;
    logic [2:0] conv_mode;
    logic [1:0] osr_sel;

    int checks = 0;
    int errors = 0;

    // Bench model
    logic [7:0]  m_mem [32];
    logic [15:0] m_d1, m_d2;
    logic [1:0]  m_rdy;
    logic        m_last;
    logic [4:0]  bp;

    always #2.5 clk = ~clk;

    capbank_if #(.GAIN1_DEFAULT(G1), .GAIN2_DEFAULT(G2)) uut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .res_load(res_load), .res_chan(res_chan), .res_value(res_value),
        .ch1_en(ch1_en), .ch2_en(ch2_en), .conv_mode(conv_mode), .osr_sel(osr_sel)
    );

    function automatic logic [7:0] bmask(input int a);
        case (a)
            5, 6, 7, 8, 9, 10, 12, 13: return 8'hFF;
            11, 14: return 8'hE0;
            15: return 8'h1F;
            17, 18: return 8'h9F;
            26: return 8'h30;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic [4:0] a);
        case (a)
            5'd0: return {5'b0, m_last, m_rdy};
            5'd1: return m_d1[15:8];
            5'd2: return m_d1[7:0];
            5'd3: return m_d2[15:8];
            5'd4: return m_d2[7:0];
            default: return m_mem[a];
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_mem[i] = 8'h00;
        m_mem[5] = 8'h80; m_mem[7] = 8'h80;
        m_mem[9] = G1[15:8]; m_mem[10] = G1[7:0];
        m_mem[12] = G2[15:8]; m_mem[13] = G2[7:0];
        m_d1 = '0; m_d2 = '0; m_rdy = 2'b11; m_last = 1'b0; bp = '0;
    endtask

    task automatic op_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
    endtask

    task automatic op_stop();
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
    endtask

    task automatic op_ptr(input logic [7:0] b);
        @(negedge clk) begin wr_valid = 1'b1; wr_data = b; end
        @(negedge clk) wr_valid = 1'b0;
        bp = b[4:0];
    endtask

    task automatic op_write(input logic [7:0] b);
        @(negedge clk) begin wr_valid = 1'b1; wr_data = b; end
        @(negedge clk) wr_valid = 1'b0;
        m_mem[bp] = m_mem[bp] & ~bmask(int'(bp)) | (b & bmask(int'(bp)));
        bp = bp + 1'b1;
    endtask

    task automatic op_read(input string tag);
        logic [7:0] e;
        e = exp_rd(bp);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) begin
            rd_req = 1'b0;
            check(tag, {8'h00, rd_data}, {8'h00, e});
        end
        if (bp == 5'd2) m_rdy[0] = 1'b1;
        if (bp == 5'd4) m_rdy[1] = 1'b1;
        bp = bp + 1'b1;
    endtask

    task automatic op_result(input logic ch, input logic [11:0] v, input logic taken);
        @(negedge clk) begin res_load = 1'b1; res_chan = ch; res_value = v; end
        @(negedge clk) res_load = 1'b0;
        if (taken) begin
            if (ch) m_d2 = {v, 4'h0}; else m_d1 = {v, 4'h0};
            m_rdy[ch] = 1'b0;
            m_last = ch;
        end
    endtask

    // R1: every byte after reset
    task automatic test_reset();
        check("R1 rd_data reset", {8'h00, rd_data}, 16'h0000);
        check("R9 cfg outputs reset", {9'b0, ch1_en, ch2_en, conv_mode, osr_sel}, 16'h0000);
        op_start(); op_ptr(8'h00); op_start();
        for (int i = 0; i < 32; i++) op_read($sformatf("R1 default addr %0d", i));
        op_stop();
    endtask

    // R8, R9: masks and configuration outputs
    task automatic test_masks();
        op_start(); op_ptr(8'h0B);
        for (int i = 0; i < 8; i++) op_write(8'hFF);
        op_stop();
        check("R9 ch1_en", {15'b0, ch1_en}, 16'h1);
        check("R9 ch2_en", {15'b0, ch2_en}, 16'h1);
        check("R9 conv_mode", {13'b0, conv_mode}, 16'h7);
        op_start(); op_ptr(8'h1A); op_write(8'hFF); op_stop();
        check("R9 osr_sel", {14'b0, osr_sel}, 16'h3);
        op_start(); op_ptr(8'h0F); op_write(8'h0A); op_stop();
        check("R9 conv_mode partial", {13'b0, conv_mode}, 16'h2);
        check("R9 ch2_en partial", {15'b0, ch2_en}, 16'h1);
        check("R9 ch1_en partial", {15'b0, ch1_en}, 16'h0);
        op_start(); op_ptr(8'h0B); op_start();
        for (int i = 0; i < 8; i++) op_read("R8 masked readback");
        op_start(); op_ptr(8'h1A); op_start(); op_read("R8 cfg2 mask");
        op_stop();
    endtask

    // R7: read-only and unmapped bytes
    task automatic test_readonly();
        op_start(); op_ptr(8'h00);
        for (int i = 0; i < 5; i++) op_write(8'h55);
        op_stop();
        op_start(); op_ptr(8'h13);
        for (int i = 0; i < 7; i++) op_write(8'hAA);
        op_stop();
        op_start(); op_ptr(8'h00); op_start();
        for (int i = 0; i < 5; i++) op_read("R7 read-only unchanged");
        op_start(); op_ptr(8'h13); op_start();
        for (int i = 0; i < 7; i++) op_read("R7 unmapped reads zero");
        op_stop();
    endtask

    // R3, R4, R5: pointer load, retention, wrap
    task automatic test_pointer();
        op_start(); op_ptr(8'h1F); op_start();
        op_read("R5 read at 0x1F");
        op_read("R5 wrap to 0x00");
        op_stop();
        op_start(); op_ptr(8'hE5); op_stop();   // upper bits dropped, ptr 0x05
        op_start(); op_read("R4 retained pointer at 0x05");
        op_read("R5 advance to 0x06");
        op_stop();
        op_start(); op_ptr(8'h06); op_write(8'h3C); op_write(8'hC3);
        op_start(); op_ptr(8'h06); op_start();
        op_read("R3 write after pointer byte"); op_read("R5 write advanced");
        op_stop();
    endtask

    // R2: strobes in IDLE ignored, start wins over stop
    task automatic test_idle();
        logic [7:0] held;
        op_start(); op_ptr(8'h07); op_stop();
        held = rd_data;
        @(negedge clk) begin wr_valid = 1'b1; wr_data = 8'h11; end
        @(negedge clk) begin wr_valid = 1'b0; rd_req = 1'b1; end
        @(negedge clk) rd_req = 1'b0;
        check("R2 idle read ignored", {8'h00, rd_data}, {8'h00, held});
        op_start(); op_read("R2 idle write left pointer and byte");
        op_stop();
        @(negedge clk) begin bus_start = 1'b1; bus_stop = 1'b1; end
        @(negedge clk) begin bus_start = 1'b0; bus_stop = 1'b0; end
        op_ptr(8'h05); op_read("R2 start wins over stop");
        @(negedge clk) begin bus_stop = 1'b1; wr_valid = 1'b1; wr_data = 8'h99; end
        @(negedge clk) begin bus_stop = 1'b0; wr_valid = 1'b0; end
        op_start(); op_ptr(8'h06); op_start();
        op_read("R2 byte with stop ignored");
        op_stop();
    endtask

    // R6, R10, R11: results and status
    task automatic test_results();
        op_result(1'b0, 12'hABC, 1'b1);
        op_start(); op_ptr(8'h00); op_start();
        op_read("R10 status after ch0 load");
        check("R6 rd_data holds", {8'h00, rd_data}, 16'h0002);
        op_read("R10 ch0 high"); op_read("R10 ch0 low");
        op_start(); op_ptr(8'h00); op_start();
        op_read("R11 ready restored");
        op_stop();
        op_result(1'b1, 12'h123, 1'b1);
        op_start(); op_ptr(8'h00); op_start();
        op_read("R10 status after ch1 load");
        op_read("R10 ch0 kept"); op_read("R10 ch0 kept lo");
        op_read("R10 ch1 high"); op_read("R10 ch1 low");
        op_start(); op_ptr(8'h00); op_start();
        op_read("R11 ch1 ready restored");
        op_stop();
    endtask

    // R12: result dropped during a read
    task automatic test_lock();
        op_start(); op_ptr(8'h01); op_start();
        op_read("R12 first byte");
        op_result(1'b0, 12'h555, 1'b0);
        op_read("R12 second byte unchanged");
        op_stop();
        op_start(); op_ptr(8'h01); op_start();
        op_read("R12 lost result high");
        op_stop();
        op_result(1'b0, 12'h777, 1'b1);
        op_start(); op_ptr(8'h01); op_start();
        op_read("R12 accepted after stop");
        op_stop();
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_masks();
        test_readonly();
        test_pointer();
        test_idle();
        test_results();
        test_lock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule